// File: doc/BRIEF.md
# Three-wire serial memory command controller

This block is the device side of a three-wire serial memory link. A host selects the device with a chip-select line. It then clocks frames in on a serial data input, one bit per serial-clock rising edge. Each frame is a start bit, a two-bit opcode, an address and, for data-carrying commands, a data word. The controller decodes the frame. It answers reads on the serial output. It holds a write-enable latch, and it applies programming commands to a small register array that stands in for nonvolatile storage.

A programming command does not act when its frame ends. It is held pending until chip select has stayed low for a minimum number of system clocks. At that point a self-timed busy period of a fixed number of system clocks begins, and it needs no serial clocking. The host polls the busy period by selecting the device again and reading the output line. The serial inputs are sampled in the system clock domain, so a serial-clock rising edge is seen as a low-to-high change between two system clock samples.

Top module: `mw_eeprom`

## Requirements
- R1: After reset every word of the array holds all ones and the write-enable latch is clear. While the latch is clear, write, erase, erase-all and write-all frames leave the array unchanged and start no busy period.
- R2: A frame with opcode 00 whose two most significant address bits are 11 sets the latch. Opcode 00 with top bits 00 clears it. Between those frames the latch holds its value, and programming commands do not clear it.
- R3: A read frame uses opcode 10. Once its address is complete, DO drives a 0 dummy bit. Each later SK rising edge then presents the next bit of the addressed word, MSB first. This works whatever the state of the latch.
- R4: A write frame is opcode 01, then the address MSB first, then the data word MSB first. It stores that word at that address only.
- R5: An erase frame is opcode 11 and an address. It sets every bit of that word to 1 and leaves the other words unchanged.
- R6: An erase-all frame is opcode 00 with top address bits 10. It sets every bit of every word to 1.
- R7: A write-all frame is opcode 00 with top address bits 01, followed by a data word. It stores that word in every location, with no erase needed first.
- R8: A pending programming command starts only after CS has been low for CS_MIN consecutive system clocks. If CS returns high after fewer clocks than that, the command is discarded.
- R9: Once started, the busy period lasts exactly BUSY_CYCLES system clocks, with no SK activity needed.
- R10: While CS is high and no read is in progress, DO is 0 during the busy period and 1 otherwise. DO is not driven (do_oe low) whenever CS is low.
- R11: A selection that begins during the busy period is ignored entirely, even if the busy period ends while that selection is still open.
- R12: Zeros clocked in before the start bit are skipped. Bits clocked in after a complete frame have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data in |
| do_data | output | 1 | Serial data out value |
| do_oe | output | 1 | Output enable for DO; low means high impedance |

## Verification
Two events can fall on the same system clock. One is the host reselecting the device. The other is the deselect counter reaching its limit and starting the program cycle. The bench provokes this by holding the deselect for exactly CS_MIN clocks and for one clock fewer. In the first case it expects a busy status on the next poll; in the second it expects ready and an unchanged word on read-back. The bench also lets the busy period end in the middle of a frame that was started during it. It judges that frame ignored by showing that a later write still runs a busy period and that the word reads back as written.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    XC_DISABLE  = 2'b00,
    XC_FILL     = 2'b01,
    XC_CLEARALL = 2'b10,
    XC_ENABLE   = 2'b11
  } xcmd_e;

  typedef enum logic [2:0] {
    PK_NONE,
    PK_WRITE,
    PK_ERASE,
    PK_CLEARALL,
    PK_FILL
  } pend_e;

  function automatic logic touches_all(input pend_e k);
    return (k == PK_CLEARALL) || (k == PK_FILL);
  endfunction

  function automatic logic touches_one(input pend_e k);
    return (k == PK_WRITE) || (k == PK_ERASE);
  endfunction

  function automatic logic loads_ones(input pend_e k);
    return (k == PK_ERASE) || (k == PK_CLEARALL);
  endfunction

endpackage

// File: rtl/mw_frame.sv
module mw_frame #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sk_rise,
  input  logic              di,
  output logic              hdr_stb,
  output logic              data_stb,
  output logic [1:0]        op,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  localparam int HDR_W = 2 + ADDR_W;
  localparam int FRM_W = HDR_W + DATA_W;
  localparam int CNT_W = $clog2(FRM_W + 1);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] FRM_LAST = CNT_W'(FRM_W - 1);
  localparam logic [CNT_W-1:0] FRM_END  = CNT_W'(FRM_W);

  logic             started;
  logic [CNT_W-1:0] cnt;
  logic [FRM_W-1:0] sr;
  logic [FRM_W-1:0] sr_nx;

  assign sr_nx = {sr[FRM_W-2:0], di};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started  <= 1'b0;
      cnt      <= '0;
      sr       <= '0;
      hdr_stb  <= 1'b0;
      data_stb <= 1'b0;
      op       <= '0;
      addr     <= '0;
      data     <= '0;
    end else begin
      hdr_stb  <= 1'b0;
      data_stb <= 1'b0;
      if (!en) begin
        started <= 1'b0;
        cnt     <= '0;
      end else if (sk_rise) begin
        if (!started) begin
          started <= di;
        end else if (cnt != FRM_END) begin
          sr  <= sr_nx;
          cnt <= cnt + 1'b1;
          if (cnt == HDR_LAST) begin
            hdr_stb <= 1'b1;
            op      <= sr_nx[HDR_W-1 -: 2];
            addr    <= sr_nx[ADDR_W-1:0];
          end
          if (cnt == FRM_LAST) begin
            data_stb <= 1'b1;
            data     <= sr_nx[DATA_W-1:0];
          end
        end
      end
    end
  end
endmodule

// File: rtl/mw_array.sv
module mw_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_one,
  input  logic              fill,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (fill || (we_one && (wr_addr == ADDR_W'(i)))) mem[i] <= wr_data;
      end
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 2000,
  parameter int CS_MIN      = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_data,
  output logic do_oe
);
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
  localparam int LOW_W  = $clog2(CS_MIN + 1);
  localparam logic [BUSY_W-1:0] BUSY_LAST = BUSY_W'(BUSY_CYCLES - 1);
  localparam logic [LOW_W-1:0]  LOW_LAST  = LOW_W'(CS_MIN - 1);

  logic sk_q, cs_q, sk_rise, cs_rise;
  logic sel_ok, frame_en;
  logic hdr_stb, data_stb;
  logic [1:0]        f_op;
  logic [ADDR_W-1:0] f_addr;
  logic [DATA_W-1:0] f_data;
  op_e   op;
  xcmd_e xsel;

  logic              wel;
  pend_e             pend_kind;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;
  logic              busy;
  logic [BUSY_W-1:0] busy_cnt;
  logic [LOW_W-1:0]  low_cnt;
  logic              prog_start;
  logic              rd_active, rd_dummy;
  logic [DATA_W-1:0] rd_sr, rd_word, wr_word;

  assign sk_rise  = sk & ~sk_q;
  assign cs_rise  = cs & ~cs_q;
  assign frame_en = cs & sel_ok;
  assign op       = op_e'(f_op);
  assign xsel     = xcmd_e'(f_addr[ADDR_W-1 -: 2]);

  assign prog_start = !cs && !busy && (pend_kind != PK_NONE) && (low_cnt == LOW_LAST);
  assign wr_word    = loads_ones(pend_kind) ? '1 : pend_data;

  mw_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .en(frame_en), .sk_rise(sk_rise), .di(di),
    .hdr_stb(hdr_stb), .data_stb(data_stb),
    .op(f_op), .addr(f_addr), .data(f_data)
  );

  mw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .we_one(prog_start && touches_one(pend_kind)),
    .fill(prog_start && touches_all(pend_kind)),
    .wr_addr(pend_addr), .wr_data(wr_word),
    .rd_addr(f_addr), .rd_data(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_q    <= 1'b0;
      cs_q    <= 1'b0;
      sel_ok  <= 1'b0;
      low_cnt <= '0;
    end else begin
      sk_q <= sk;
      cs_q <= cs;
      if (!cs)         sel_ok <= 1'b0;
      else if (cs_rise) sel_ok <= !busy;
      if (cs)                       low_cnt <= '0;
      else if (low_cnt != LOW_LAST) low_cnt <= low_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel       <= 1'b0;
      pend_kind <= PK_NONE;
      pend_addr <= '0;
      pend_data <= '0;
      busy      <= 1'b0;
      busy_cnt  <= '0;
    end else begin
      if (cs_rise) pend_kind <= PK_NONE;
      if (hdr_stb) begin
        case (op)
          OP_EXT: begin
            if (xsel == XC_ENABLE)  wel <= 1'b1;
            if (xsel == XC_DISABLE) wel <= 1'b0;
            if (xsel == XC_CLEARALL && wel) pend_kind <= PK_CLEARALL;
          end
          OP_ERASE: if (wel) begin
            pend_kind <= PK_ERASE;
            pend_addr <= f_addr;
          end
          default: ;
        endcase
      end
      if (data_stb && wel) begin
        if (op == OP_WRITE) begin
          pend_kind <= PK_WRITE;
          pend_addr <= f_addr;
          pend_data <= f_data;
        end else if (op == OP_EXT && xsel == XC_FILL) begin
          pend_kind <= PK_FILL;
          pend_data <= f_data;
        end
      end
      if (prog_start) begin
        pend_kind <= PK_NONE;
        busy      <= 1'b1;
        busy_cnt  <= BUSY_LAST;
      end else if (busy) begin
        if (busy_cnt == '0) busy <= 1'b0;
        else                busy_cnt <= busy_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_active <= 1'b0;
      rd_dummy  <= 1'b0;
      rd_sr     <= '0;
    end else if (!cs) begin
      rd_active <= 1'b0;
    end else if (hdr_stb && op == OP_READ) begin
      rd_active <= 1'b1;
      rd_dummy  <= 1'b1;
      rd_sr     <= rd_word;
    end else if (rd_active && sk_rise) begin
      if (rd_dummy) rd_dummy <= 1'b0;
      else          rd_sr    <= {rd_sr[DATA_W-2:0], 1'b0};
    end
  end

  assign do_oe   = cs;
  assign do_data = rd_active ? (!rd_dummy && rd_sr[DATA_W-1]) : !busy;
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic do_data,
  input logic do_oe,
  input logic wel,
  input logic busy,
  input logic prog_start,
  input logic hdr_stb,
  input logic data_stb,
  input logic rd_active
);
  a_r1_start_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> wel);

  a_r2_latch_only_on_header: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_stb |=> $stable(wel));

  a_r3_dummy_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_active) |-> !do_data);

  a_r8_start_while_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> (!cs && !do_oe));

  a_r9_busy_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> busy);

  a_r10_hiz_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> !do_oe);

  a_r10_busy_reads_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && busy && !rd_active) |-> !do_data);

  a_r11_no_decode_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!hdr_stb && !data_stb));
endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .do_data(do_data), .do_oe(do_oe),
  .wel(wel), .busy(busy), .prog_start(prog_start),
  .hdr_stb(hdr_stb), .data_stb(data_stb), .rd_active(rd_active)
);

// File: tb/mw_eeprom_test.sv
`timescale 1ns/1ps
module mw_eeprom_test;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int BUSY = 20;
  localparam int CSM = 4;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_data, do_oe;
  int total = 0;
  int fails = 0;
  logic [DW-1:0] model [NW];
  logic [DW-1:0] got;

  always #2.5 clk = ~clk;

  mw_eeprom #(.ADDR_W(AW), .DATA_W(DW), .BUSY_CYCLES(BUSY), .CS_MIN(CSM)) uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
    .do_data(do_data), .do_oe(do_oe)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 37 + 5) % 256);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sk_bit(input logic b);
    @(negedge clk) di = b;
    repeat (2) @(negedge clk);
    sk = 1'b1;
    repeat (2) @(negedge clk);
    sk = 1'b0;
  endtask

  task automatic send(input int n, input logic [31:0] v);
    for (int i = n - 1; i >= 0; i--) sk_bit(v[i]);
  endtask

  task automatic sel();
    @(negedge clk) cs = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic desel(input int n);
    @(negedge clk) begin cs = 1'b0; sk = 1'b0; end
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic cmd(input logic [1:0] op, input logic [AW-1:0] a,
                     input bit has_d, input logic [DW-1:0] d);
    sel();
    sk_bit(1'b1);
    send(2, op);
    send(AW, a);
    if (has_d) send(DW, d);
  endtask

  // deselect for the minimum, then poll: busy first, ready after the period
  task automatic run_prog(input string req);
    desel(CSM);
    sel();
    chk(req, do_data, 0);
    repeat (BUSY) @(negedge clk);
    chk(req, do_data, 1);
    desel(2);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] w);
    sel();
    sk_bit(1'b1);
    send(2, 2'b10);
    send(AW, a);
    repeat (2) @(negedge clk);
    chk("R3 dummy", do_data, 0);
    w = '0;
    for (int i = 0; i < DW; i++) begin
      sk_bit(1'b0);
      w = {w[DW-2:0], do_data};
    end
    desel(2);
  endtask

  initial begin
    #(5.0 * 200000);
    total++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) model[i] = '1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 hiz", do_oe, 0);
    sel();
    chk("R10 ready", do_data, 1);
    desel(2);
    rd(0, got);
    chk("R1 reset word", got, 8'hFF);

    // R1: programming refused with latch clear
    cmd(2'b01, 2, 1, 8'h33);
    desel(CSM); sel();
    chk("R1 no busy", do_data, 1);
    desel(2);
    cmd(2'b00, 4'b1000, 0, '0);
    desel(CSM); sel();
    chk("R1 no busy eral", do_data, 1);
    desel(2);
    rd(2, got);
    chk("R1 unchanged", got, 8'hFF);

    // R2: enable, then sweep writes; latch must survive each
    cmd(2'b00, 4'b1100, 0, '0);
    desel(2);
    for (int a = 0; a < NW; a++) begin
      cmd(2'b01, AW'(a), 1, pat(a));
      run_prog("R2 R4 write");
      model[a] = pat(a);
    end
    for (int a = 0; a < NW; a++) begin
      rd(AW'(a), got);
      chk("R4 readback", got, model[a]);
    end

    // R12: leading zeros and trailing bits
    sel();
    sk_bit(1'b0); sk_bit(1'b0); sk_bit(1'b1);
    send(2, 2'b01); send(AW, 5); send(DW, 8'hC6);
    sk_bit(1'b1); sk_bit(1'b1); sk_bit(1'b0);
    run_prog("R12 framed");
    model[5] = 8'hC6;
    rd(5, got);
    chk("R12 word", got, 8'hC6);

    // R8: one clock short aborts
    cmd(2'b01, 6, 1, 8'h00);
    desel(CSM - 1); sel();
    chk("R8 short abort", do_data, 1);
    desel(CSM + 2); sel();
    chk("R8 dropped", do_data, 1);
    desel(2);
    rd(6, got);
    chk("R8 unchanged", got, model[6]);

    // R5: erase one word
    cmd(2'b11, 3, 0, '0);
    run_prog("R5 erase");
    model[3] = 8'hFF;
    rd(3, got);
    chk("R5 erased", got, 8'hFF);
    rd(4, got);
    chk("R5 neighbour", got, model[4]);

    // R11: disable frame sent while busy is ignored
    cmd(2'b01, 7, 1, 8'h11);
    desel(CSM); sel();
    model[7] = 8'h11;
    sk_bit(1'b1); send(2, 2'b00); send(AW, 4'b0000);
    desel(2);
    cmd(2'b01, 8, 1, 8'h22);
    run_prog("R11 latch kept");
    model[8] = 8'h22;
    rd(8, got);
    chk("R11 word", got, 8'h22);
    rd(7, got);
    chk("R11 prior", got, 8'h11);

    // R9: exact busy length
    cmd(2'b01, 9, 1, 8'h99);
    desel(CSM); sel();
    model[9] = 8'h99;
    repeat (BUSY - 3) @(negedge clk);
    chk("R9 last busy", do_data, 0);
    @(negedge clk);
    chk("R9 first ready", do_data, 1);
    desel(2);

    // R7: fill
    cmd(2'b00, 4'b0100, 1, 8'h5A);
    run_prog("R7 fill");
    for (int a = 0; a < NW; a++) begin
      rd(AW'(a), got);
      chk("R7 filled", got, 8'h5A);
    end

    // R6: clear all
    cmd(2'b00, 4'b1000, 0, '0);
    run_prog("R6 clear");
    for (int a = 0; a < NW; a++) begin
      rd(AW'(a), got);
      chk("R6 ones", got, 8'hFF);
    end

    // R2 disable, R3 read with latch clear
    cmd(2'b01, 1, 1, 8'h44);
    run_prog("R2 before disable");
    cmd(2'b00, 4'b0000, 0, '0);
    desel(2);
    cmd(2'b01, 1, 1, 8'h77);
    desel(CSM); sel();
    chk("R2 disabled", do_data, 1);
    desel(2);
    rd(1, got);
    chk("R3 read disabled", got, 8'h44);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule